// File: doc/BRIEF.md
# Instruction Cache with Non-Blocking Line Fill

This block is a set-associative instruction cache that keeps one valid bit and one tag per line. Its storage is written only by whole-line fills from the memory side. When a fetch misses, the block requests the line starting with the 64-bit double-word that the fetch asked for. The remaining double-words follow in wrapping order. The fetch port waits only until that first double-word is on the memory bus. After that, fetches that hit other lines are served at once, and fetches to the line still being loaded are served as soon as their double-word has arrived.

A fetch presents a byte address and is held until `fetch_rdy` is high. In that cycle `fetch_data` carries the addressed double-word. Address bits [2:0] are ignored, bits [BI_W+2:3] pick the double-word inside the line, the next log2(SETS) bits pick the set, and the remaining high bits are the tag. One fill may be outstanding at a time. A single-cycle `inv_all` pulse clears every valid bit at once, because the cache does not watch stores to memory and keeping it coherent is left to software.

Top module: `icf_core`

## Requirements
- R1: After reset no line is valid, `fetch_rdy` and `mem_req` are low while no fetch is presented, and the first fetch to any address misses.
- R2: A fetch to a valid line is served in the same cycle with the addressed double-word, and `mem_req` stays low.
- R3: A miss with no fill in progress raises `mem_req` for exactly one cycle, with `mem_addr` equal to the fetch address with bits [2:0] cleared. No new request is made while four beats of the previous fill are still outstanding.
- R4: The four beats of a fill are written in order: critical double-word index k first, then (k+1) mod 4, (k+2) mod 4 and (k+3) mod 4. After the fill, each double-word of the line reads back its own memory value.
- R5: A missing fetch is served in the cycle in which the critical beat is on `mem_beat_valid`, and not before.
- R6: During a fill, a fetch to another double-word of the same line is served in the cycle its beat arrives, or at once if that beat already arrived. No new request is made for it.
- R7: During a fill, fetches that hit other valid lines are served with no stall.
- R8: A miss to a different line during a fill stalls until the fourth beat has been written. Its own request is issued in the cycle after that beat.
- R9: A line becomes valid only when its fourth beat is written. From then on all of its double-words hit.
- R10: The way that receives a fill is the lowest-numbered invalid way of the set. If every way is valid, it is chosen by a three-bit tree pseudo-LRU that is updated on every hit and on every fill start. Example: after fills into ways 0,1,2,3 in that order and then a hit on way 0, the next miss replaces way 2.
- R11: In the cycle `inv_all` is high, no fetch is served and no fill starts. From the next cycle every line is invalid. A fill in flight during the pulse still completes and forwards its data, but it leaves its line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until served |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_rdy | output | 1 | Fetch served this cycle |
| fetch_data | output | 64 | Addressed double-word, valid with `fetch_rdy` |
| inv_all | input | 1 | Invalidate every line |
| mem_req | output | 1 | Single-cycle line fill request |
| mem_addr | output | ADDR_W | Critical double-word address of the fill |
| mem_beat_valid | input | 1 | Fill beat present |
| mem_beat_data | input | 64 | Fill beat data |

## Verification
The bench builds the block with 8 sets, 4 ways and 32-byte lines. The small set count means a single set can be filled to all four ways with a few addresses, so invalid-way preference and a known pseudo-LRU eviction can both be driven directly. The bench's memory model inserts an idle cycle between beats. Because of that gap, the forwarding timing is visible per beat: whether a fetch is served in the exact cycle its beat arrives and not earlier, whether fetches to other lines go through while the fill is still running, and whether a second miss waits for the fourth beat.

// File: rtl/icf_pkg.sv
package icf_pkg;
   localparam int DW_W     = 64;
   localparam int DW_BYTES = DW_W / 8;
   typedef logic [DW_W-1:0] dword_t;
endpackage

// File: rtl/icf_tags.sv
module icf_tags #(
   parameter  int SETS  = 128,
   parameter  int WAYS  = 4,
   parameter  int TAG_W = 20,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic             free_ok,
   output logic [WAY_W-1:0] free_way,
   input  logic             alloc_en,
   input  logic [SET_W-1:0] alloc_set,
   input  logic [WAY_W-1:0] alloc_way,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             commit_en,
   input  logic [SET_W-1:0] commit_set,
   input  logic [WAY_W-1:0] commit_way,
   input  logic             flush
);
   logic [WAYS-1:0]  vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];

   // valid bits: flush dominates, allocation drops the old line, commit sets it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (alloc_en)  vld_q[alloc_set][alloc_way]   <= 1'b0;
         if (commit_en) vld_q[commit_set][commit_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_en) tag_q[alloc_set][alloc_way] <= alloc_tag;
   end

   // lowest way index wins for both hit and free selection
   always_comb begin
      hit      = 1'b0;
      hit_way  = '0;
      free_ok  = 1'b0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
         if (!vld_q[lk_set][w]) begin
            free_ok  = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/icf_plru.sv
module icf_plru #(
   parameter  int SETS  = 128,
   parameter  int WAYS  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAY_W-1:0] victim,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way
);
   generate
      if (WAYS == 2) begin : g_two
         logic [SETS-1:0] b_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        b_q <= '0;
            else if (touch_en) b_q[rd_set] <= ~touch_way[0];
         end
         assign victim = b_q[rd_set];
      end else begin : g_tree
         // [0] root: 1 -> victim in ways 2/3; [1] left pair; [2] right pair
         logic [2:0] t_q [SETS];
         logic [2:0] t_cur;
         assign t_cur  = t_q[rd_set];
         assign victim = t_cur[0] ? {1'b1, t_cur[2]} : {1'b0, t_cur[1]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) t_q[s] <= '0;
            end else if (touch_en) begin
               if (touch_way[1]) t_q[rd_set] <= {~touch_way[0], t_cur[1], 1'b0};
               else              t_q[rd_set] <= {t_cur[2], ~touch_way[0], 1'b1};
            end
         end
      end
   endgenerate
endmodule

// File: rtl/icf_core.sv
module icf_core #(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 128,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_rdy,
   output logic [63:0]       fetch_data,
   input  logic              inv_all,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_beat_valid,
   input  logic [63:0]       mem_beat_data
);
   import icf_pkg::*;

   localparam int BEATS = LINE_BYTES / DW_BYTES;
   localparam int BI_W  = $clog2(BEATS);
   localparam int DWO_W = $clog2(DW_BYTES);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - OFF_W - SET_W;
   localparam int DA_W  = SET_W + WAY_W + BI_W;

   if (WAYS != 2 && WAYS != 4) begin : g_bad_ways
      $error("icf_core: WAYS must be 2 or 4");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("icf_core: SETS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 * DW_BYTES || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("icf_core: LINE_BYTES must be a power of two holding two or more double-words");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("icf_core: address too narrow for the geometry");
   end

   // fetch address fields
   logic [SET_W-1:0] fa_set;
   logic [TAG_W-1:0] fa_tag;
   logic [BI_W-1:0]  fa_dw;
   assign fa_set = fetch_addr[OFF_W +: SET_W];
   assign fa_tag = fetch_addr[ADDR_W-1 -: TAG_W];
   assign fa_dw  = fetch_addr[DWO_W +: BI_W];

   // fill tracker
   logic             fill_act_q, fill_stale_q;
   logic [SET_W-1:0] fill_set_q;
   logic [TAG_W-1:0] fill_tag_q;
   logic [WAY_W-1:0] fill_way_q;
   logic [BI_W-1:0]  fill_crit_q, fill_cnt_q;
   logic [BEATS-1:0] fill_have_q;

   dword_t data_q [2**DA_W];

   logic             arr_hit, free_ok, beat_in, beat_last, same_line, beat_now, fwd_ok, miss;
   logic [WAY_W-1:0] hit_way, free_way, lru_way, victim_way;
   logic [BI_W-1:0]  in_idx;

   assign in_idx     = fill_crit_q + fill_cnt_q;
   assign beat_in    = fill_act_q && mem_beat_valid;
   assign beat_last  = beat_in && (fill_cnt_q == BI_W'(BEATS - 1));
   assign same_line  = fill_act_q && (fa_set == fill_set_q) && (fa_tag == fill_tag_q);
   assign beat_now   = beat_in && (in_idx == fa_dw);
   assign fwd_ok     = same_line && (fill_have_q[fa_dw] || beat_now);
   assign victim_way = free_ok ? free_way : lru_way;

   assign fetch_rdy  = fetch_req && !inv_all && (arr_hit || fwd_ok);
   assign miss       = fetch_req && !inv_all && !arr_hit && !same_line;
   assign mem_req    = miss && !fill_act_q;
   assign mem_addr   = fetch_addr & ~ADDR_W'(DW_BYTES - 1);

   always_comb begin
      if (arr_hit)       fetch_data = data_q[{fa_set, hit_way, fa_dw}];
      else if (beat_now) fetch_data = mem_beat_data;
      else               fetch_data = data_q[{fill_set_q, fill_way_q, fa_dw}];
   end

   icf_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_set     (fa_set),
      .lk_tag     (fa_tag),
      .hit        (arr_hit),
      .hit_way    (hit_way),
      .free_ok    (free_ok),
      .free_way   (free_way),
      .alloc_en   (mem_req),
      .alloc_set  (fa_set),
      .alloc_way  (victim_way),
      .alloc_tag  (fa_tag),
      .commit_en  (beat_last && !fill_stale_q && !inv_all),
      .commit_set (fill_set_q),
      .commit_way (fill_way_q),
      .flush      (inv_all)
   );

   icf_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_set    (fa_set),
      .victim    (lru_way),
      .touch_en  (mem_req || (fetch_rdy && arr_hit)),
      .touch_way (mem_req ? victim_way : hit_way)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_act_q   <= 1'b0;
         fill_stale_q <= 1'b0;
         fill_set_q   <= '0;
         fill_tag_q   <= '0;
         fill_way_q   <= '0;
         fill_crit_q  <= '0;
         fill_cnt_q   <= '0;
         fill_have_q  <= '0;
      end else if (mem_req) begin
         fill_act_q   <= 1'b1;
         fill_stale_q <= 1'b0;
         fill_set_q   <= fa_set;
         fill_tag_q   <= fa_tag;
         fill_way_q   <= victim_way;
         fill_crit_q  <= fa_dw;
         fill_cnt_q   <= '0;
         fill_have_q  <= '0;
      end else begin
         if (inv_all && fill_act_q) fill_stale_q <= 1'b1;
         if (beat_in) begin
            fill_cnt_q          <= fill_cnt_q + 1'b1;
            fill_have_q[in_idx] <= 1'b1;
            if (beat_last) fill_act_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (beat_in) data_q[{fill_set_q, fill_way_q, in_idx}] <= mem_beat_data;
   end
endmodule

// File: rtl/icf_core_chk.sv
module icf_core_chk (
   input logic clk,
   input logic rst_n,
   input logic fetch_req,
   input logic fetch_rdy,
   input logic inv_all,
   input logic mem_req,
   input logic mem_beat_valid
);
   logic       busy_q;
   logic [2:0] nbeat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         nbeat_q <= '0;
      end else if (mem_req) begin
         busy_q  <= 1'b1;
         nbeat_q <= '0;
      end else if (busy_q && mem_beat_valid) begin
         nbeat_q <= nbeat_q + 3'd1;
         if (nbeat_q == 3'd3) busy_q <= 1'b0;
      end
   end

   // R3
   fill_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !busy_q);

   // R3
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R2
   served_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_rdy |-> !mem_req);

   // R11
   inv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |-> (!fetch_rdy && !mem_req));

   // R5
   rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_rdy |-> fetch_req);
endmodule

bind icf_core icf_core_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_req      (fetch_req),
   .fetch_rdy      (fetch_rdy),
   .inv_all        (inv_all),
   .mem_req        (mem_req),
   .mem_beat_valid (mem_beat_valid)
);

// File: tb/tb_icf_core.sv
module tb_icf_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_rdy;
   logic [63:0] fetch_data;
   logic        inv_all = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_beat_valid = 1'b0;
   logic [63:0] mem_beat_data = '0;

   int nchk = 0, nerr = 0, cyc = 0;
   int beats_sent = 0, req_cnt = 0, fills_done = 0, overlap = 0;
   logic resp_busy = 1'b0;
   logic [31:0] last_req = '0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   icf_core #(.ADDR_W(32), .SETS(8), .WAYS(4), .LINE_BYTES(32)) dut (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_rdy(fetch_rdy), .fetch_data(fetch_data), .inv_all(inv_all),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_beat_valid(mem_beat_valid),
      .mem_beat_data(mem_beat_data));

   // address: tag [31:8], set [7:5], double-word [4:3]
   function automatic logic [31:0] ad(int tag, int set, int dw);
      return {24'(tag), 3'(set), 2'(dw), 3'b000};
   endfunction

   function automatic logic [63:0] memdw(logic [31:0] a);
      logic [31:0] al;
      al = {a[31:3], 3'b000};
      return {32'h600D_0000 ^ al, al};
   endfunction

   // memory model: one idle cycle before the first beat and between beats
   always begin
      @(posedge clk);
      if (rst_n && mem_req) begin
         req_cnt++;
         last_req   = mem_addr;
         resp_busy  = 1'b1;
         beats_sent = 0;
         @(posedge clk);
         for (int i = 0; i < 4; i++) begin
            logic [1:0] bi;
            bi = last_req[4:3] + 2'(i);
            #1;
            mem_beat_valid = 1'b1;
            mem_beat_data  = memdw({last_req[31:5], bi, 3'b000});
            @(posedge clk);
            beats_sent++;
            #1;
            mem_beat_valid = 1'b0;
            if (i < 3) @(posedge clk);
         end
         fills_done++;
         resp_busy = 1'b0;
      end
   end

   always @(negedge clk) if (rst_n && mem_req && resp_busy) overlap++;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic fetch(input logic [31:0] a, output logic [63:0] d, output int waitc,
                        output int bsent, output logic bv);
      fetch_req  = 1'b1;
      fetch_addr = a;
      waitc = 0;
      forever begin
         @(negedge clk);
         if (fetch_rdy) break;
         waitc++;
         if (waitc > 500) break;
      end
      d = fetch_data; bsent = beats_sent; bv = mem_beat_valid;
      @(posedge clk); #1;
      fetch_req = 1'b0;
   endtask

   task automatic wait_idle();
      while (resp_busy) begin @(posedge clk); #1; end
   endtask

   task automatic fill_line(input logic [31:0] a);
      logic [63:0] d; int w, b; logic v;
      fetch(a, d, w, b, v);
      wait_idle();
   endtask

   task automatic t_reset();
      logic [63:0] d; int w, b; logic v;
      @(negedge clk);
      chk(fetch_rdy == 1'b0, "R1 rdy in reset", 64'(fetch_rdy), 64'd0);
      chk(mem_req == 1'b0, "R1 req in reset", 64'(mem_req), 64'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(posedge clk); #1;
      fetch(ad(1, 1, 2), d, w, b, v);
      chk(w > 0, "R1 first fetch misses", 64'(w), 64'd1);
      wait_idle();
   endtask

   task automatic t_critical_forward();
      logic [63:0] d; int w, b, r0; logic v;
      inv_all = 1'b1; @(posedge clk); #1; inv_all = 1'b0;
      r0 = req_cnt;
      fetch(ad(1, 1, 2), d, w, b, v);
      chk(d == memdw(ad(1, 1, 2)), "R5 critical data", d, memdw(ad(1, 1, 2)));
      chk(b == 0 && v == 1'b1, "R5 served with critical beat", 64'(b), 64'd0);
      chk(req_cnt == r0 + 1, "R3 one request", 64'(req_cnt), 64'(r0 + 1));
      chk(last_req == ad(1, 1, 2), "R3 request address", 64'(last_req), 64'(ad(1, 1, 2)));
      fetch(ad(1, 1, 3), d, w, b, v);
      chk(d == memdw(ad(1, 1, 3)) && b == 1 && v, "R6 forward second beat", d, memdw(ad(1, 1, 3)));
      fetch(ad(1, 1, 1), d, w, b, v);
      chk(d == memdw(ad(1, 1, 1)) && b == 3 && v, "R6 forward last beat", d, memdw(ad(1, 1, 1)));
      wait_idle();
      chk(req_cnt == r0 + 1, "R6 no extra request", 64'(req_cnt), 64'(r0 + 1));
   endtask

   task automatic t_hit_all();
      logic [63:0] d; int w, b, r0; logic v;
      r0 = req_cnt;
      for (int k = 0; k < 4; k++) begin
         fetch(ad(1, 1, k), d, w, b, v);
         chk(w == 0 && d == memdw(ad(1, 1, k)), "R2 R4 R9 hit after fill", d, memdw(ad(1, 1, k)));
      end
      chk(req_cnt == r0, "R2 hits make no request", 64'(req_cnt), 64'(r0));
   endtask

   task automatic t_other_hit();
      logic [63:0] d; int w, b, f0; logic v;
      fill_line(ad(2, 3, 0));
      f0 = fills_done;
      fetch(ad(3, 4, 1), d, w, b, v);
      fetch(ad(2, 3, 2), d, w, b, v);
      chk(w == 0 && d == memdw(ad(2, 3, 2)), "R7 hit during fill", d, memdw(ad(2, 3, 2)));
      chk(b < 4 && fills_done == f0, "R7 fill still running", 64'(b), 64'd1);
      wait_idle();
   endtask

   task automatic t_second_miss();
      logic [63:0] d; int w, b, f0, r0; logic v;
      f0 = fills_done; r0 = req_cnt;
      fetch(ad(4, 5, 0), d, w, b, v);
      fetch(ad(5, 6, 3), d, w, b, v);
      chk(fills_done == f0 + 1, "R8 waited for first fill", 64'(fills_done), 64'(f0 + 1));
      chk(req_cnt == r0 + 2 && last_req == ad(5, 6, 3), "R8 second request", 64'(last_req), 64'(ad(5, 6, 3)));
      chk(d == memdw(ad(5, 6, 3)) && b == 0 && v, "R8 second critical", d, memdw(ad(5, 6, 3)));
      wait_idle();
      chk(overlap == 0, "R3 R8 no overlapping request", 64'(overlap), 64'd0);
   endtask

   task automatic t_replace();
      logic [63:0] d; int w, b, r0; logic v;
      inv_all = 1'b1; @(posedge clk); #1; inv_all = 1'b0;
      for (int t = 10; t < 14; t++) fill_line(ad(t, 7, 0));
      fetch(ad(10, 7, 0), d, w, b, v);
      chk(w == 0, "R10 invalid ways filled first", 64'(w), 64'd0);
      fill_line(ad(14, 7, 0));
      r0 = req_cnt;
      fetch(ad(10, 7, 1), d, w, b, v);
      chk(w == 0 && d == memdw(ad(10, 7, 1)), "R10 way0 kept", d, memdw(ad(10, 7, 1)));
      fetch(ad(11, 7, 1), d, w, b, v);
      chk(w == 0, "R10 way1 kept", 64'(w), 64'd0);
      fetch(ad(13, 7, 1), d, w, b, v);
      chk(w == 0, "R10 way3 kept", 64'(w), 64'd0);
      chk(req_cnt == r0, "R10 no request for kept", 64'(req_cnt), 64'(r0));
      fetch(ad(12, 7, 1), d, w, b, v);
      chk(w > 0 && req_cnt == r0 + 1, "R10 way2 evicted", 64'(req_cnt), 64'(r0 + 1));
      wait_idle();
   endtask

   task automatic t_invalidate();
      logic [63:0] d; int w, b, r0; logic v;
      fill_line(ad(6, 2, 0));
      fetch_req = 1'b1; fetch_addr = ad(6, 2, 0); inv_all = 1'b1;
      @(negedge clk);
      chk(fetch_rdy == 1'b0 && mem_req == 1'b0, "R11 stall during pulse", 64'(fetch_rdy), 64'd0);
      @(posedge clk); #1; inv_all = 1'b0;
      @(negedge clk);
      chk(fetch_rdy == 1'b0 && mem_req == 1'b1, "R11 line dropped", 64'(mem_req), 64'd1);
      @(posedge clk); #1;
      fetch(ad(6, 2, 0), d, w, b, v);
      chk(d == memdw(ad(6, 2, 0)), "R11 refetch data", d, memdw(ad(6, 2, 0)));
      wait_idle();
      fetch(ad(7, 2, 1), d, w, b, v);
      inv_all = 1'b1; @(posedge clk); #1; inv_all = 1'b0;
      fetch(ad(7, 2, 2), d, w, b, v);
      chk(d == memdw(ad(7, 2, 2)), "R11 stale fill still forwards", d, memdw(ad(7, 2, 2)));
      wait_idle();
      r0 = req_cnt;
      fetch(ad(7, 2, 1), d, w, b, v);
      chk(w > 0 && req_cnt == r0 + 1, "R11 stale fill left invalid", 64'(req_cnt), 64'(r0 + 1));
      wait_idle();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      t_critical_forward();
      t_hit_all();
      t_other_hit();
      t_second_miss();
      t_replace();
      t_invalidate();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule